// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

This block sits at the writeback point of an out-of-order core where finished results from several producers compete for one shared result bus. It has one holding slot per producer: four load buffers, four floating-point adders and one integer unit, nine in all by default. A producer finishes an operation and pushes its result into its slot with a one-cycle strobe. The push carries a 64-bit value, a destination register tag and the issue sequence number of the instruction. Store and branch operations produce no register result and have no connection to the block.

In every cycle the block chooses, from all occupied slots, the one whose instruction was issued earliest. It broadcasts that result on a registered bus as a valid bit, tag and value, and gives the winning producer a one-cycle acknowledge in the same cycle. Slots that lose keep their contents and their age and compete again in the next cycle. Sequence numbers are compared modulo their width, so the ordering stays correct when the issue counter wraps. A flush input, with a flush point, empties every slot that holds an instruction younger than that point.

Top module: `cdb_arbiter`

## Requirements
- R1: At most one result is broadcast per clock cycle. `ack` has at most one bit set, and it is nonzero only in a cycle where `bus_valid` is high.
- R2: A pushed result that loses arbitration is kept, with its tag, value and sequence number unchanged, until it is broadcast or flushed. No pushed result is lost.
- R3: When several slots are occupied, the slot whose sequence number is oldest is broadcast first. Sequence numbers are unique while in flight.
- R4: Age is decided by the sign bit of the SEQ_W-bit difference: a is older than b when bit SEQ_W-1 of (a - b) mod 2^SEQ_W is 1. With SEQ_W=6, 62 is older than 63, and 63 is older than 1.
- R5: `bus_tag` and `bus_data` are registered together with `bus_valid`. They carry the tag and value pushed by the producer whose bit is set in `ack` in that same cycle. Bit i of `ack` belongs to producer i, in this order: loads 0..3, adders 4..7, integer unit 8.
- R6: A result pushed in cycle t appears on the bus in cycle t+2 at the earliest. It never appears in cycle t+1.
- R7: While `flush_valid` is high, every occupied slot whose sequence number is strictly younger than `flush_seq` is emptied and never broadcast. Slots that are equal in age or older are kept and may be granted in that cycle.
- R8: A push that arrives in a flush cycle with a sequence number strictly younger than `flush_seq` is discarded. An older push in the same cycle is kept.
- R9: While `rst_n` is low at a clock edge, all slots are emptied and `bus_valid` and `ack` are driven low. `bus_valid` stays low while no slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | NUM_SRC | One-cycle result strobe per producer |
| push_tag | input | NUM_SRC*TAG_W | Destination tag per producer, producer i at bits i*TAG_W upward |
| push_seq | input | NUM_SRC*SEQ_W | Issue sequence number per producer |
| push_data | input | NUM_SRC*DATA_W | Result value per producer |
| flush_valid | input | 1 | Flush request this cycle |
| flush_seq | input | SEQ_W | Flush point; strictly younger entries are removed |
| ack | output | NUM_SRC | One-cycle acknowledge to the producer being broadcast |
| bus_valid | output | 1 | Broadcast valid |
| bus_tag | output | TAG_W | Broadcast destination tag |
| bus_data | output | DATA_W | Broadcast result value |

## Verification
The assertions assume that a producer pushes only into an empty slot. That is the cycle after its acknowledge or later, or before it ever pushed. They also assume that all in-flight sequence numbers lie within half the counter range of each other, so the modulo comparison gives a total order. The stimulus pushes each producer at most once per test phase and waits for the bus to drain before it reuses a slot. It chooses sequence numbers that are unique and span less than 32, including a set that crosses the wrap from 63 to 1. Flush points are placed between live sequence numbers, so both the kept and the removed sides of R7 and R8 are exercised.

// File: rtl/cdb_pkg.sv
// Shared helpers for the result bus arbiter.
// Assumes live sequence numbers span less than half of 2^w.
package cdb_pkg;

    // Modulo-2^w age test: true when a was issued before b.
    function automatic logic seq_older(input logic [63:0] a,
                                       input logic [63:0] b,
                                       input int unsigned w);
        logic [63:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/cdb_slot.sv
// Holding slot for one producer's finished result.
// Captures a push, keeps it until it is granted or flushed, and reports
// whether it may compete this cycle. Assumes a push only into an empty slot.
module cdb_slot #(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned SEQ_W  = 6,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flush_valid,
    input  logic [SEQ_W-1:0]  flush_seq,
    input  logic              grant,
    output logic              occupied,
    output logic              eligible,
    output logic [TAG_W-1:0]  held_tag,
    output logic [SEQ_W-1:0]  held_seq,
    output logic [DATA_W-1:0] held_data
);
    import cdb_pkg::*;

    logic valid_q;
    logic kill_held;
    logic kill_new;

    // Flush decisions: remove entries strictly younger than the flush point.
    always_comb begin
        kill_held = flush_valid && valid_q &&
                    seq_older(64'(flush_seq), 64'(held_seq), SEQ_W);
        kill_new  = flush_valid &&
                    seq_older(64'(flush_seq), 64'(push_seq), SEQ_W);
    end

    // Slot occupancy: fill on push, empty on grant or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (push && !kill_new) begin
            valid_q <= 1'b1;
        end else if (grant || kill_held) begin
            valid_q <= 1'b0;
        end
    end

    // Payload capture on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_tag  <= '0;
            held_seq  <= '0;
            held_data <= '0;
        end else if (push && !kill_new) begin
            held_tag  <= push_tag;
            held_seq  <= push_seq;
            held_data <= push_data;
        end
    end

    assign occupied = valid_q;
    assign eligible = valid_q && !kill_held;

    // R2
    push_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !valid_q);

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !grant && !kill_held) |=>
        (valid_q && $stable(held_seq) && $stable(held_tag) && $stable(held_data)));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_held |=> !valid_q);

endmodule

// File: rtl/cdb_oldest_pick.sv
// Oldest-first selector over the eligible slots.
// Produces a one-hot (or empty) grant vector. Equal sequence numbers are
// not expected; if they occur, the lower index wins.
module cdb_oldest_pick #(
    parameter int unsigned NUM_SRC = 9,
    parameter int unsigned SEQ_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         elig,
    input  logic [NUM_SRC*SEQ_W-1:0]   seq_flat,
    output logic [NUM_SRC-1:0]         gnt
);
    import cdb_pkg::*;

    // Every candidate is knocked out by any eligible older rival.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            gnt[i] = elig[i];
            for (int j = 0; j < NUM_SRC; j++) begin
                if (j != i && elig[j]) begin
                    if (seq_older(64'(seq_flat[j*SEQ_W +: SEQ_W]),
                                  64'(seq_flat[i*SEQ_W +: SEQ_W]), SEQ_W) ||
                        (seq_flat[j*SEQ_W +: SEQ_W] == seq_flat[i*SEQ_W +: SEQ_W]
                         && j < i)) begin
                        gnt[i] = 1'b0;
                    end
                end
            end
        end
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_win
        for (genvar gj = 0; gj < NUM_SRC; gj++) begin : g_rival
            if (gi != gj) begin : g_pair
                // R3
                oldest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt[gi] && elig[gj]) |->
                    !seq_older(64'(seq_flat[gj*SEQ_W +: SEQ_W]),
                               64'(seq_flat[gi*SEQ_W +: SEQ_W]), SEQ_W));
            end
        end
    end

endmodule

// File: rtl/cdb_arbiter.sv
// Result bus arbiter: one holding slot per producer, oldest-first grant,
// registered broadcast with a matching one-cycle acknowledge.
// Assumes producers push only into empty slots, and that live sequence
// numbers span less than half the counter range.
module cdb_arbiter #(
    parameter int unsigned N_LOAD = 4,
    parameter int unsigned N_FADD = 4,
    parameter int unsigned N_INT  = 1,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned SEQ_W  = 6,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned NUM_SRC = N_LOAD + N_FADD + N_INT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          push,
    input  logic [NUM_SRC*TAG_W-1:0]    push_tag,
    input  logic [NUM_SRC*SEQ_W-1:0]    push_seq,
    input  logic [NUM_SRC*DATA_W-1:0]   push_data,
    input  logic                        flush_valid,
    input  logic [SEQ_W-1:0]            flush_seq,
    output logic [NUM_SRC-1:0]          ack,
    output logic                        bus_valid,
    output logic [TAG_W-1:0]            bus_tag,
    output logic [DATA_W-1:0]           bus_data
);
    logic [NUM_SRC-1:0]        occ;
    logic [NUM_SRC-1:0]        elig;
    logic [NUM_SRC-1:0]        gnt;
    logic [NUM_SRC*TAG_W-1:0]  h_tag;
    logic [NUM_SRC*SEQ_W-1:0]  h_seq;
    logic [NUM_SRC*DATA_W-1:0] h_data;
    logic [TAG_W-1:0]          win_tag;
    logic [DATA_W-1:0]         win_data;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        cdb_slot #(
            .TAG_W (TAG_W),
            .SEQ_W (SEQ_W),
            .DATA_W(DATA_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push[s]),
            .push_tag   (push_tag[s*TAG_W +: TAG_W]),
            .push_seq   (push_seq[s*SEQ_W +: SEQ_W]),
            .push_data  (push_data[s*DATA_W +: DATA_W]),
            .flush_valid(flush_valid),
            .flush_seq  (flush_seq),
            .grant      (gnt[s]),
            .occupied   (occ[s]),
            .eligible   (elig[s]),
            .held_tag   (h_tag[s*TAG_W +: TAG_W]),
            .held_seq   (h_seq[s*SEQ_W +: SEQ_W]),
            .held_data  (h_data[s*DATA_W +: DATA_W])
        );
    end

    cdb_oldest_pick #(
        .NUM_SRC(NUM_SRC),
        .SEQ_W  (SEQ_W)
    ) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .seq_flat(h_seq),
        .gnt     (gnt)
    );

    // Winner payload mux: OR of the grant-masked slot contents.
    always_comb begin
        win_tag  = '0;
        win_data = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            win_tag  |= h_tag[k*TAG_W +: TAG_W]    & {TAG_W{gnt[k]}};
            win_data |= h_data[k*DATA_W +: DATA_W] & {DATA_W{gnt[k]}};
        end
    end

    // Broadcast register: valid, tag, value and acknowledge move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            ack       <= '0;
            bus_tag   <= '0;
            bus_data  <= '0;
        end else begin
            bus_valid <= |gnt;
            ack       <= gnt;
            if (|gnt) begin
                bus_tag  <= win_tag;
                bus_data <= win_data;
            end
        end
    end

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack) && (bus_valid || ack == '0));

    // R6
    bus_from_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $past(|occ));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |=> !bus_valid);

endmodule

// File: tb/cdb_arbiter_bench.sv
module cdb_arbiter_bench;
    localparam int NS = 9;
    localparam int TW = 6;
    localparam int SW = 6;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    push = '0;
    logic [NS*TW-1:0] push_tag = '0;
    logic [NS*SW-1:0] push_seq = '0;
    logic [NS*DW-1:0] push_data = '0;
    logic             flush_valid = 1'b0;
    logic [SW-1:0]    flush_seq = '0;
    logic [NS-1:0]    ack;
    logic             bus_valid;
    logic [TW-1:0]    bus_tag;
    logic [DW-1:0]    bus_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0]    idx;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    cdb_arbiter u_cdb_arbiter (
        .clk(clk), .rst_n(rst_n), .push(push), .push_tag(push_tag),
        .push_seq(push_seq), .push_data(push_data), .flush_valid(flush_valid),
        .flush_seq(flush_seq), .ack(ack), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_data(bus_data)
    );

    function automatic logic [TW-1:0] tag_of(int idx, int seq);
        return TW'(seq + 3 * idx + 1);
    endfunction

    function automatic logic [DW-1:0] data_of(int idx, int seq);
        return 64'hA5C3_0000_0000_0000 | (64'(idx) << 16) | 64'(seq);
    endfunction

    // Driver: stage one push and record the expected broadcast if wanted.
    task automatic stage(int idx, int seq, bit expect_it);
        push[idx] = 1'b1;
        push_tag[idx*TW +: TW]  = tag_of(idx, seq);
        push_seq[idx*SW +: SW]  = SW'(seq);
        push_data[idx*DW +: DW] = data_of(idx, seq);
        if (expect_it) begin
            expq.push_back('{idx: 8'(idx), tag: tag_of(idx, seq), data: data_of(idx, seq)});
        end
    endtask

    task automatic release_cycle();
        @(negedge clk);
        push = '0;
        flush_valid = 1'b0;
    endtask

    task automatic drain(string req);
        repeat (25) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL %s: pending expected broadcasts actual=%0d expected=0", req, expq.size());
            expq.delete();
        end
    endtask

    // Monitor: compare every broadcast against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (!bus_valid && ack != '0) begin
                    checks++;
                    failures++;
                    $display("FAIL R1: ack without bus_valid actual=%b expected=0", ack);
                end
                if (bus_valid) begin
                    checks++;
                    if (expq.size() == 0) begin
                        failures++;
                        $display("FAIL R2/R7: unexpected broadcast tag=%0d ack=%b expected=none",
                                 bus_tag, ack);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        if (ack != (NS'(1) << e.idx) || bus_tag != e.tag || bus_data != e.data) begin
                            failures++;
                            $display("FAIL R3/R5: actual ack=%b tag=%0d data=%h expected ack=%b tag=%0d data=%h",
                                     ack, bus_tag, bus_data, NS'(1) << e.idx, e.tag, e.data);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (bus_valid !== 1'b0 || ack !== '0) begin
            failures++;
            $display("FAIL R9: actual valid=%b ack=%b expected valid=0 ack=0", bus_valid, ack);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: latency of a lone push
        stage(2, 5, 1'b1);
        release_cycle();
        checks++;
        if (bus_valid !== 1'b0) begin
            failures++;
            $display("FAIL R6: one cycle after push actual valid=%b expected=0", bus_valid);
        end
        @(negedge clk);
        checks++;
        if (bus_valid !== 1'b1 || ack !== 9'b000000100) begin
            failures++;
            $display("FAIL R6: two cycles after push actual valid=%b ack=%b expected valid=1 ack=000000100",
                     bus_valid, ack);
        end
        drain("R6");

        // R3 R2 R1: three at once, oldest first
        expq.push_back('{idx: 8'd5, tag: tag_of(5, 7), data: data_of(5, 7)});
        expq.push_back('{idx: 8'd1, tag: tag_of(1, 10), data: data_of(1, 10)});
        expq.push_back('{idx: 8'd8, tag: tag_of(8, 12), data: data_of(8, 12)});
        stage(1, 10, 1'b0); stage(5, 7, 1'b0); stage(8, 12, 1'b0);
        release_cycle();
        drain("R3");

        // R4: sequence numbers across the wrap
        expq.push_back('{idx: 8'd0, tag: tag_of(0, 62), data: data_of(0, 62)});
        expq.push_back('{idx: 8'd1, tag: tag_of(1, 63), data: data_of(1, 63)});
        expq.push_back('{idx: 8'd2, tag: tag_of(2, 1), data: data_of(2, 1)});
        stage(2, 1, 1'b0); stage(0, 62, 1'b0); stage(1, 63, 1'b0);
        release_cycle();
        drain("R4");

        // R2 R3: an older late arrival overtakes a waiting loser
        expq.push_back('{idx: 8'd0, tag: tag_of(0, 30), data: data_of(0, 30)});
        expq.push_back('{idx: 8'd2, tag: tag_of(2, 29), data: data_of(2, 29)});
        expq.push_back('{idx: 8'd1, tag: tag_of(1, 31), data: data_of(1, 31)});
        stage(0, 30, 1'b0); stage(1, 31, 1'b0);
        release_cycle();
        stage(2, 29, 1'b0);
        release_cycle();
        drain("R2");

        // R7: flush removes strictly younger held entries
        stage(0, 40, 1'b1); stage(1, 41, 1'b1);
        stage(2, 42, 1'b0); stage(3, 43, 1'b0);
        release_cycle();
        flush_valid = 1'b1; flush_seq = 6'd41;
        release_cycle();
        drain("R7");

        // R7: flushed slot is empty and reusable
        stage(3, 44, 1'b1);
        release_cycle();
        drain("R7");

        // R8: same-cycle push younger than the flush point is dropped
        stage(4, 50, 1'b0); stage(5, 44, 1'b1);
        flush_valid = 1'b1; flush_seq = 6'd45;
        release_cycle();
        drain("R8");

        // R1 R3: all producers at once, descending age by index
        for (int k = NS - 1; k >= 0; k--) begin
            expq.push_back('{idx: 8'(k), tag: tag_of(k, 20 - k), data: data_of(k, 20 - k)});
        end
        for (int k = 0; k < NS; k++) stage(k, 20 - k, 1'b0);
        release_cycle();
        drain("R1");

        // R9: quiet bus after drain, then reset mid-traffic clears slots
        checks++;
        if (bus_valid !== 1'b0) begin
            failures++;
            $display("FAIL R9: idle actual valid=%b expected=0", bus_valid);
        end
        stage(6, 9, 1'b0); stage(7, 8, 1'b0);
        release_cycle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        checks++;
        if (bus_valid !== 1'b0 || ack !== '0) begin
            failures++;
            $display("FAIL R9: after reset actual valid=%b ack=%b expected valid=0 ack=0", bus_valid, ack);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule